// File: doc/BRIEF.md
# Bypass FIFO with Occupancy Level

This block is a synchronous first-in first-out queue with a depth set at compile time. When the queue holds nothing, a word offered on the write side shows up on the head output in the same cycle. A consumer can therefore take that word in the cycle it arrives, and it never occupies a storage slot. When the queue holds some words, it behaves as an ordinary register-array FIFO with separate read and write pointers.

Alongside the data path the block reports whether it is full or empty and how many words it holds. It also raises two flags that compare this count against fixed low and high marks. A producer watches `push_ready_o`. A consumer watches `head_valid_o` and pulses `pop_i` to take the head word. A synchronous clear empties the queue in one cycle.

Top module: `bypass_level_fifo`

## Requirements
- R1: After reset, `empty_o`=1, `full_o`=0, `count_o`=0, `push_ready_o`=1 and `head_valid_o`=0 while no push is offered.
- R2: Words leave through `head_o` in the order they were accepted.
- R3: While empty, `push_i`=1 makes `head_valid_o`=1 and `head_o`=`push_data_i` in the same cycle. If `pop_i` is also 1, the word is consumed and `count_o` stays 0.
- R4: While neither empty nor full, a simultaneous push and pop leaves `count_o` unchanged and keeps the order.
- R5: `full_o`=1 and `push_ready_o`=0 exactly when `count_o`=DEPTH. A push while full is dropped: the count does not change and the word never appears at the head.
- R6: A pop while empty with no push has no effect: `count_o` stays 0 and `empty_o` stays 1.
- R7: `count_o` is $clog2(DEPTH+1) bits wide and stays within 0 to DEPTH. It rises by one on an accepted push alone and falls by one on an accepted pop alone.
- R8: `below_low_o` = (`count_o` < LOW_MARK) and `above_high_o` = (`count_o` > HIGH_MARK).
- R9: `clear_i`=1 at a clock edge leaves the queue empty with `count_o`=0, whatever push or pop is offered in that cycle.
- R10: When full, a simultaneous push and pop removes the head word and rejects the push, so `count_o` becomes DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of all contents |
| push_i | input | 1 | Write request |
| push_data_i | input | DATA_W | Write word |
| push_ready_o | output | 1 | Queue can accept a write |
| pop_i | input | 1 | Read request |
| head_o | output | DATA_W | Oldest word, or the incoming word when empty |
| head_valid_o | output | 1 | `head_o` carries a word |
| full_o | output | 1 | Count equals DEPTH |
| empty_o | output | 1 | Count equals zero |
| count_o | output | CNT_W | Number of stored words |
| below_low_o | output | 1 | Count below LOW_MARK |
| above_high_o | output | 1 | Count above HIGH_MARK |

## Verification
A wrong pointer shows up on `head_o` the next time that slot reaches the head. With a partly full queue this can be up to DEPTH pops later, so the bench drains the queue completely after each phase. A wrong count appears on `count_o` and the threshold flags in the cycle after the bad update. A bypass that wrongly stores its word only appears later, as an extra word at the head after the queue next drains. For that reason, every phase is followed by reads until empty.

// File: rtl/bypass_fifo_pkg.sv
package bypass_fifo_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_IN   = 2'b01,
    OP_OUT  = 2'b10,
    OP_SWAP = 2'b11
  } fifo_op_e;

  function automatic int ptr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl
  import bypass_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  fifo_op_e         op;
  logic [PTR_W-1:0] wr_ptr_nxt, rd_ptr_nxt;
  logic [CNT_W-1:0] count_nxt;

  always_comb begin
    op         = fifo_op_e'({rd_en, wr_en});
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    count_nxt  = count;
    if (wr_en) wr_ptr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    if (rd_en) rd_ptr_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    unique case (op)
      OP_IN:   count_nxt = count + 1'b1;
      OP_OUT:  count_nxt = count - 1'b1;
      default: count_nxt = count;
    endcase
    if (clear) begin
      wr_ptr_nxt = '0;
      rd_ptr_nxt = '0;
      count_nxt  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      count  <= count_nxt;
    end
  end

  assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT && !rd_en && !clear) |=> (count == FULL_CNT));
endmodule

// File: rtl/fifo_regfile.sv
module fifo_regfile #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = we && (waddr == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (slot_en) slot[i] <= wdata;
    end
  end

  assign rdata = slot[raddr];
endmodule

// File: rtl/fifo_level_cmp.sv
module fifo_level_cmp #(
  parameter int CNT_W     = 3,
  parameter int LOW_MARK  = 1,
  parameter int HIGH_MARK = 3
) (
  input  logic [CNT_W-1:0] count,
  output logic             below_low,
  output logic             above_high
);
  localparam logic [CNT_W:0] LOW_V  = (CNT_W+1)'(LOW_MARK);
  localparam logic [CNT_W:0] HIGH_V = (CNT_W+1)'(HIGH_MARK);

  always_comb begin
    below_low  = {1'b0, count} < LOW_V;
    above_high = {1'b0, count} > HIGH_V;
  end
endmodule

// File: rtl/bypass_level_fifo.sv
module bypass_level_fifo
  import bypass_fifo_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 4,
  parameter int LOW_MARK  = 1,
  parameter int HIGH_MARK = 3,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int PTR_W    = ptr_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic              push_ready_o,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              head_valid_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              below_low_o,
  output logic              above_high_o
);
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [DATA_W-1:0] stored_head;
  logic              push_take, pop_take, pass_thru, store_wr, store_rd;

  always_comb begin
    empty_o      = (count_o == '0);
    full_o       = (count_o == CNT_W'(DEPTH));
    push_ready_o = !full_o;
    head_valid_o = !empty_o || push_i;
    head_o       = empty_o ? push_data_i : stored_head;
    push_take    = push_i && !full_o;
    pop_take     = pop_i && head_valid_o;
    pass_thru    = empty_o && push_i && pop_i;
    store_wr     = push_take && !pass_thru;
    store_rd     = pop_take && !pass_thru;
  end

  fifo_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clear(clear_i),
    .wr_en(store_wr), .rd_en(store_rd),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count_o)
  );

  fifo_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_mem (
    .clk(clk), .we(store_wr), .waddr(wr_ptr), .wdata(push_data_i),
    .raddr(rd_ptr), .rdata(stored_head)
  );

  fifo_level_cmp #(.CNT_W(CNT_W), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)) u_lvl (
    .count(count_o), .below_low(below_low_o), .above_high(above_high_o)
  );

  assert_bypass_keeps_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && push_i && pop_i) |=> empty_o);
  assert_empty_pop_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i) |=> empty_o);
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (empty_o && !full_o));
  assert_full_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && pop_i && !clear_i) |=> !full_o);
endmodule

// File: tb/test_bypass_level_fifo.sv
module test_bypass_level_fifo;
  localparam int DW = 8, DEPTH = 4, LOW = 1, HIGH = 3, CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0, clear_i = 1'b0, push_i = 1'b0, pop_i = 1'b0;
  logic [DW-1:0] push_data_i = '0;
  logic push_ready_o, head_valid_o, full_o, empty_o, below_low_o, above_high_o;
  logic [DW-1:0] head_o;
  logic [CW-1:0] count_o;

  int vectors = 0, misses = 0;
  logic [DW-1:0] sb[$];

  always #4 clk = ~clk;

  bypass_level_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .LOW_MARK(LOW), .HIGH_MARK(HIGH)) i_bypass_level_fifo (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .push_i(push_i), .push_data_i(push_data_i),
    .push_ready_o(push_ready_o), .pop_i(pop_i), .head_o(head_o), .head_valid_o(head_valid_o),
    .full_o(full_o), .empty_o(empty_o), .count_o(count_o),
    .below_low_o(below_low_o), .above_high_o(above_high_o));

  task automatic chk(input string req, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus; monitor part compares against scoreboard.
  task automatic step(input logic p, input logic [DW-1:0] d, input logic q, input logic c);
    int n;
    logic bypass;
    @(negedge clk);
    push_i = p; push_data_i = d; pop_i = q; clear_i = c;
    #1;
    n = sb.size();
    chk("R7 count", int'(count_o), n);
    chk("R5 full", int'(full_o), int'(n == DEPTH));
    chk("R5 ready", int'(push_ready_o), int'(n != DEPTH));
    chk("R1/R6 empty", int'(empty_o), int'(n == 0));
    chk("R8 below", int'(below_low_o), int'(n < LOW));
    chk("R8 above", int'(above_high_o), int'(n > HIGH));
    chk("R3 head_valid", int'(head_valid_o), int'(n > 0 || p));
    if (n > 0) chk("R2 head order", int'(head_o), int'(sb[0]));
    else if (p) chk("R3 bypass data", int'(head_o), int'(d));
    bypass = (n == 0) && p && q;
    if (c) sb.delete();
    else if (!bypass) begin
      if (q && n > 0) void'(sb.pop_front());
      if (p && n < DEPTH) sb.push_back(d);
    end
  endtask

  task automatic drain();
    for (int k = 0; k < DEPTH + 1; k++) step(1'b0, '0, 1'b1, 1'b0);
  endtask

  initial begin
    #800000;
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset empty", int'(empty_o), 1);
    chk("R1 reset count", int'(count_o), 0);
    chk("R1 reset head_valid", int'(head_valid_o), 0);
    chk("R1 reset ready", int'(push_ready_o), 1);
    // R3 bypass stream
    for (int k = 0; k < 4; k++) step(1'b1, DW'(8'hA0 + k), 1'b1, 1'b0);
    // R6 pop while empty
    step(1'b0, '0, 1'b1, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0);
    // R5/R8 fill to full, push while full dropped, R7 levels
    for (int k = 0; k < DEPTH + 2; k++) step(1'b1, DW'(8'h10 + k), 1'b0, 1'b0);
    // R10 push+pop while full
    step(1'b1, 8'hEE, 1'b1, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0);
    // R4 simultaneous while partial
    for (int k = 0; k < 6; k++) step(1'b1, DW'(8'h30 + k), 1'b1, 1'b0);
    drain();
    // R9 clear with push and pop offered
    step(1'b1, 8'h51, 1'b0, 1'b0);
    step(1'b1, 8'h52, 1'b0, 1'b0);
    step(1'b1, 8'h53, 1'b1, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0);
    drain();
    // R2 random mix
    for (int k = 0; k < 400; k++)
      step(1'($urandom), DW'($urandom), 1'($urandom), 1'(($urandom % 40) == 0));
    drain();
    step(1'b0, '0, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule